// File: doc/BRIEF.md
# Adaptive Replication Level Controller

This block steers how aggressively a private cache keeps replicas of shared read-only data. It holds a replication level between 0 and 5. Two event strobes feed it: one for each local replica placed and one for each allocation in the buffer that tracks hits at the next higher level. It adds both strobes into one event count. Once that count goes past a threshold, the block runs one cost-benefit evaluation.

The evaluation reads four unsigned delta estimates supplied by external counters. Two describe a step down: the hit benefit that would be lost and the miss cost that would be saved. Two describe a step up: the hit benefit that would be gained and the miss cost that would be added. Each evaluation votes down, up or stay. The level moves only after a run of agreeing votes. Every evaluation pulses a clear to the delta counters and restarts the event count.

Top module: `replLevelCtrl`

## Requirements
- R1: After reset the level is 0 and the delta clear output is low.
- R2: Each strobe adds one to the event count, so two strobes in one cycle add two. An evaluation runs in the cycle after the count becomes strictly greater than TRIG_THRESH (default 1024). A count equal to the threshold does not start an evaluation.
- R3: In every evaluation cycle the delta clear output is high for exactly one cycle. The event count then restarts from the strobes seen in that same cycle.
- R4: When the miss-cost saving of a step down is greater than the hit-benefit loss of a step down, and a step up is not favoured, the vote is down.
- R5: When the hit-benefit gain of a step up is greater than the miss-cost increase of a step up, and a step down is not favoured, the vote is up.
- R6: When both directions are favoured, the direction with the larger net gain wins. Equal net gains give stay. When neither direction is favoured the vote is stay.
- R7: The level moves by one only after AGREE_RUNS (default 4) consecutive evaluations vote the same direction. The new level is visible in the cycle after the last agreeing evaluation, and the run count then restarts from zero.
- R8: A stay vote clears the run of agreeing votes.
- R9: A vote opposite to the current run starts a new run of length one in the new direction.
- R10: The level never leaves the range 0 to 5. A completed run that would step past a bound leaves the level unchanged and still clears the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| replEvt | input | 1 | Strobe: one local replica was placed |
| nlhbEvt | input | 1 | Strobe: one next-level hit buffer entry was allocated |
| benDec | input | DELTA_W | Hit benefit lost by stepping down one level |
| costDec | input | DELTA_W | Miss cost saved by stepping down one level |
| benInc | input | DELTA_W | Hit benefit gained by stepping up one level |
| costInc | input | DELTA_W | Miss cost added by stepping up one level |
| deltaClr | output | 1 | One-cycle pulse during each evaluation |
| level | output | LEVEL_W | Current replication level |

## Verification
The delta clear output is due one cycle after the edge that takes the event count past the threshold. A level change is due one cycle after the edge that registers the final agreeing vote. The bench keeps a behavioural model that counts events and votes at each rising edge, using the same inputs the design sees. It compares both outputs against that model at every falling edge, so every result is read one full register stage after its cause. Inputs change only after the falling-edge comparison. Directed checks then confirm the threshold edge, the run lengths and the level bounds against literal values.

// File: rtl/replPkg.sv
package replPkg;
  typedef enum logic [1:0] {
    DIR_STAY = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dirT;

  typedef struct packed {
    logic evalFire;
    logic stepUp;
    logic stepDown;
  } ctrlStrobeT;
endpackage

// File: rtl/replDatapath.sv
module replDatapath
  import replPkg::*;
#(
  parameter int TRIG_THRESH = 1024,
  parameter int DELTA_W     = 16,
  parameter int MAX_LEVEL   = 5,
  parameter int LEVEL_W     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               replEvt,
  input  logic               nlhbEvt,
  input  logic [DELTA_W-1:0] benDec,
  input  logic [DELTA_W-1:0] costDec,
  input  logic [DELTA_W-1:0] benInc,
  input  logic [DELTA_W-1:0] costInc,
  input  ctrlStrobeT         strobes,
  output logic               evalReady,
  output dirT                vote,
  output logic [LEVEL_W-1:0] level
);
  localparam int CNT_W = $clog2(TRIG_THRESH + 3);
  localparam logic [CNT_W-1:0] THRESH_C = CNT_W'(TRIG_THRESH);
  localparam logic [LEVEL_W-1:0] TOP_C = LEVEL_W'(MAX_LEVEL);

  logic [CNT_W-1:0] evtCnt;
  logic [CNT_W-1:0] incoming;
  logic downGood, upGood;
  logic [DELTA_W-1:0] netDown, netUp;

  assign incoming  = CNT_W'(replEvt) + CNT_W'(nlhbEvt);
  assign evalReady = evtCnt > THRESH_C;

  always_ff @(posedge clk) begin
    if (!rstN) evtCnt <= '0;
    else if (strobes.evalFire) evtCnt <= incoming;
    else evtCnt <= evtCnt + incoming;
  end

  always_comb begin
    downGood = costDec > benDec;
    upGood   = benInc > costInc;
    netDown  = costDec - benDec;
    netUp    = benInc - costInc;
    vote     = DIR_STAY;
    if (downGood && upGood) begin
      if (netUp > netDown) vote = DIR_UP;
      else if (netDown > netUp) vote = DIR_DOWN;
    end else if (upGood) begin
      vote = DIR_UP;
    end else if (downGood) begin
      vote = DIR_DOWN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) level <= '0;
    else if (strobes.stepUp && level != TOP_C) level <= level + 1'b1;
    else if (strobes.stepDown && level != '0) level <= level - 1'b1;
  end

  assert_level_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    level <= TOP_C);
  assert_single_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.evalFire |=> (level == $past(level) || level == $past(level) + 1'b1 ||
                          level == $past(level) - 1'b1));
  assert_hold_between_evals_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.evalFire |=> $stable(level));
  assert_clr_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.evalFire |=> !evalReady);
endmodule

// File: rtl/replCtrl.sv
module replCtrl
  import replPkg::*;
#(
  parameter int AGREE_RUNS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       evalReady,
  input  dirT        vote,
  output ctrlStrobeT strobes
);
  localparam int RUN_W = $clog2(AGREE_RUNS + 1);
  localparam logic [RUN_W-1:0] AGREE_C = RUN_W'(AGREE_RUNS);

  dirT lastDir;
  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] nextRun;
  logic runDone;

  always_comb begin
    nextRun = (vote == lastDir) ? runCnt + 1'b1 : RUN_W'(1);
    runDone = evalReady && (vote != DIR_STAY) && (nextRun == AGREE_C);
    strobes.evalFire = evalReady;
    strobes.stepUp   = runDone && (vote == DIR_UP);
    strobes.stepDown = runDone && (vote == DIR_DOWN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastDir <= DIR_STAY;
      runCnt  <= '0;
    end else if (evalReady) begin
      if (vote == DIR_STAY || runDone) begin
        lastDir <= DIR_STAY;
        runCnt  <= '0;
      end else begin
        lastDir <= vote;
        runCnt  <= nextRun;
      end
    end
  end

  assert_one_move_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.stepUp && strobes.stepDown));
  assert_run_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    runCnt < AGREE_C);
  assert_stay_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evalReady && vote == DIR_STAY) |=> runCnt == '0);
  assert_move_needs_eval_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepUp || strobes.stepDown) |-> evalReady);
endmodule

// File: rtl/replLevelCtrl.sv
module replLevelCtrl
  import replPkg::*;
#(
  parameter int TRIG_THRESH = 1024,
  parameter int AGREE_RUNS  = 4,
  parameter int DELTA_W     = 16,
  parameter int MAX_LEVEL   = 5,
  parameter int LEVEL_W     = $clog2(MAX_LEVEL + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               replEvt,
  input  logic               nlhbEvt,
  input  logic [DELTA_W-1:0] benDec,
  input  logic [DELTA_W-1:0] costDec,
  input  logic [DELTA_W-1:0] benInc,
  input  logic [DELTA_W-1:0] costInc,
  output logic               deltaClr,
  output logic [LEVEL_W-1:0] level
);
  ctrlStrobeT strobes;
  logic evalReady;
  dirT vote;

  replDatapath #(
    .TRIG_THRESH(TRIG_THRESH), .DELTA_W(DELTA_W),
    .MAX_LEVEL(MAX_LEVEL), .LEVEL_W(LEVEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .replEvt(replEvt), .nlhbEvt(nlhbEvt),
    .benDec(benDec), .costDec(costDec), .benInc(benInc), .costInc(costInc),
    .strobes(strobes), .evalReady(evalReady), .vote(vote), .level(level)
  );

  replCtrl #(.AGREE_RUNS(AGREE_RUNS)) u_ctrl (
    .clk(clk), .rstN(rstN), .evalReady(evalReady), .vote(vote), .strobes(strobes)
  );

  assign deltaClr = strobes.evalFire;
endmodule

// File: tb/replLevelCtrl_tb.sv
module replLevelCtrl_tb;
  localparam int T = 6;
  localparam int AG = 4;
  localparam int DW = 16;

  logic clk = 0, rstN = 0, replEvt = 0, nlhbEvt = 0;
  logic [DW-1:0] benDec = 0, costDec = 0, benInc = 0, costInc = 0;
  logic deltaClr;
  logic [2:0] level;

  int total = 0, bad = 0, clrSeen = 0;
  int mCnt = 0, mRun = 0, mDir = 0, mLvl = 0; // mDir: 0 stay, 1 up, 2 down
  bit mClr;

  replLevelCtrl #(.TRIG_THRESH(T), .AGREE_RUNS(AG), .DELTA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .replEvt(replEvt), .nlhbEvt(nlhbEvt),
    .benDec(benDec), .costDec(costDec), .benInc(benInc), .costInc(costInc),
    .deltaClr(deltaClr), .level(level));

  always #2 clk = ~clk;

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    int inc, v, nd, nu, nr;
    inc = int'(replEvt) + int'(nlhbEvt);
    if (!rstN) begin
      mCnt = 0; mRun = 0; mDir = 0; mLvl = 0;
    end else if (mCnt > T) begin
      nd = int'(costDec) - int'(benDec);
      nu = int'(benInc) - int'(costInc);
      v = 0;
      if (nd > 0 && nu > 0) v = (nu > nd) ? 1 : (nd > nu) ? 2 : 0;
      else if (nu > 0) v = 1;
      else if (nd > 0) v = 2;
      if (v == 0) begin mRun = 0; mDir = 0; end
      else begin
        nr = (v == mDir) ? mRun + 1 : 1;
        if (nr == AG) begin
          if (v == 1 && mLvl < 5) mLvl++;
          if (v == 2 && mLvl > 0) mLvl--;
          mRun = 0; mDir = 0;
        end else begin mRun = nr; mDir = v; end
      end
      mCnt = inc;
    end else mCnt += inc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (rstN) begin
    mClr = (mCnt > T);
    if (deltaClr) clrSeen++;
    chk(deltaClr == mClr, "R3 deltaClr vs model", int'(deltaClr), int'(mClr));
    chk(int'(level) == mLvl, "R7 level vs model", int'(level), mLvl);
  end

  task automatic evalOnce(input int bd, input int cd, input int bi, input int ci);
    @(negedge clk); #1;
    benDec = DW'(bd); costDec = DW'(cd); benInc = DW'(bi); costInc = DW'(ci);
    for (int i = 0; i < 4; i++) begin
      replEvt = 1; nlhbEvt = 1;
      @(negedge clk); #1;
    end
    replEvt = 0; nlhbEvt = 0;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic up(input int n);   for (int i = 0; i < n; i++) evalOnce(1, 0, 5, 2); endtask
  task automatic down(input int n); for (int i = 0; i < n; i++) evalOnce(3, 9, 0, 1); endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    chk(level == 0 && deltaClr == 0, "R1 reset state", int'(level), 0);
    #1 rstN = 1;

    // R2: exactly T events must not trigger, one more must
    for (int i = 0; i < T; i++) begin replEvt = 1; @(negedge clk); #1; end
    replEvt = 0;
    repeat (3) @(negedge clk);
    chk(clrSeen == 0, "R2 no eval at threshold", clrSeen, 0);
    #1 replEvt = 1; @(negedge clk); #1 replEvt = 0;
    repeat (2) @(negedge clk);
    chk(clrSeen == 1, "R2 eval above threshold", clrSeen, 1);
    #1;

    up(3);
    chk(level == 0, "R7 no move after three votes", int'(level), 0);
    up(1);
    chk(level == 1, "R5 up after four votes", int'(level), 1);
    down(4);
    chk(level == 0, "R4 down after four votes", int'(level), 0);
    down(4);
    chk(level == 0, "R10 floor holds", int'(level), 0);
    up(2); evalOnce(5, 5, 5, 5); up(3);
    chk(level == 0, "R8 stay breaks run", int'(level), 0);
    up(1);
    chk(level == 1, "R8 run completes after stay", int'(level), 1);
    up(2); down(1); up(3);
    chk(level == 1, "R9 opposite vote restarts run", int'(level), 1);
    up(1);
    chk(level == 2, "R9 new run completes", int'(level), 2);
    for (int i = 0; i < 4; i++) evalOnce(0, 2, 9, 1);
    chk(level == 3, "R6 larger up net wins", int'(level), 3);
    for (int i = 0; i < 4; i++) evalOnce(0, 9, 3, 1);
    chk(level == 2, "R6 larger down net wins", int'(level), 2);
    for (int i = 0; i < 4; i++) evalOnce(0, 4, 6, 2);
    chk(level == 2, "R6 equal nets stay", int'(level), 2);
    up(16);
    chk(level == 5, "R10 ceiling holds", int'(level), 5);
    down(4);
    chk(level == 4, "R10 run cleared at ceiling", int'(level), 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule